// File: doc/BRIEF.md
# Two-Port Interrupt Status Aggregator

This block keeps the interrupt state of two storage ports and folds it into one level-sensitive host interrupt line. Each port has a status byte and a mask byte. Status bits are set by single-cycle event pulses from the port logic. Software clears them by writing ones. A masked bit stays visible in the status register but does not raise the port's pending flag.

A host-level status and mask pair sits above the ports. Each port's pending flag appears in the host status, next to a software-settable interrupt bit. A read-only global flag in host status reports that any unmasked host source is active. A host control register holds an interrupt-off bit that forces the output low.

Software reaches every register over a small synchronous bus. The bus carries byte and halfword writes, little-endian. Reads are combinational.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the registers hold these values:
  - Port status reads 0x00 and port mask reads 0xFF.
  - Host status reads 0x0000 and host mask reads 0x4003.
  - Host control reads 0x0100 (interrupt-off set), and `irq_out` is low.
- R2: Port event bits have these meanings, and an event pulse on bit i sets status bit i from the next clock edge:
  - bit 0: device removed
  - bit 1: device attached
  - bit 2: command done
  - bit 3: fatal error
  - bit 4: device interrupt
  - bit 5: reply queue not empty
- R3: A write to port status (bank offset 0x09) clears each of bits 0..5 written as 1 and leaves the others unchanged. Write data bits 6 and 7 have no effect.
- R4: If an event and a clearing write hit the same status bit in the same cycle, the bit is left set.
- R5: Port status bit 7 reads as the pending flag, the OR over bits 0..5 of (status AND NOT mask). Bit 6 reads 0. Mask bits 6 and 7 have no effect on pending.
- R6: Port mask (bank offset 0x0A) is an 8-bit read/write register. A set bit blocks that source; 0xFF blocks all sources, and 0x30 blocks the device-interrupt and reply sources.
- R7: Host status bit p equals port p's pending flag. Writes to those bits are ignored.
- R8: Host status and host mask are at 0xBC and 0xBE.
  - Host status bit 14 is a software interrupt bit that can be read and written.
  - Host status bit 15 is read-only and is 1 when any of host status bits 0, 1 or 14 is set while the host mask bit in the same position is clear.
  - Host mask stores only bits 0, 1 and 14; its other bits read 0.
- R9: Bit 8 of host control (0x7C) forces `irq_out` low. Otherwise `irq_out` equals host status bit 15, with no added register stage.
- R10: A halfword access covers the addressed byte in data bits 7:0 and the next byte in bits 15:8. A byte access uses bits 7:0 only and reads 0 in bits 15:8.
- R11: Port p's register bank starts at p*0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_size | input | 1 | 0 = byte, 1 = halfword |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data, addressed byte in bits 7:0 |
| bus_rdata | output | 16 | Combinational read data |
| evt_in | input | NPORTS*6 | Event pulses, port p in bits p*6+5..p*6 |
| irq_out | output | 1 | Level host interrupt |

## Verification
Two kinds of result become visible at the first rising edge after the cycle in which the stimulus is driven:
- the effect of a write on any register, and
- the effect of an event on status, pending, the global flag and `irq_out`.

Reads and the interrupt output are combinational, so they need no further cycle. The bench drives writes and events on the falling edge and holds them across one rising edge. It samples `bus_rdata` and `irq_out` one nanosecond after the next falling edge, so each check lands exactly one edge after its stimulus. The same-cycle event/clear case drives both in the same half period, so that they meet at a single edge.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NPORTS = 2,
  parameter int STRIDE = 64,
  parameter logic [7:0] MASK_RST = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            bus_addr,
  input  logic                  bus_size,
  input  logic                  bus_we,
  input  logic [15:0]           bus_wdata,
  output logic [15:0]           bus_rdata,
  input  logic [NPORTS*6-1:0]   evt_in,
  output logic                  irq_out
);
  localparam int NSRC = 6;
  localparam logic [7:0] OFS_ST = 8'h09;
  localparam logic [7:0] OFS_MK = 8'h0A;
  localparam logic [7:0] A_HCTL = 8'h7D;
  localparam logic [7:0] A_HST_L = 8'hBC;
  localparam logic [7:0] A_HST_H = 8'hBD;
  localparam logic [7:0] A_HMK_L = 8'hBE;
  localparam logic [7:0] A_HMK_H = 8'hBF;

  logic [NSRC-1:0]   st  [NPORTS];
  logic [7:0]        msk [NPORTS];
  logic [NSRC-1:0]   clr [NPORTS];
  logic [NPORTS-1:0] pend;
  logic [NPORTS-1:0] hmsk_p;
  logic              hmsk_sw, sw, off, gflag;

  logic       le0, le1;
  logic [7:0] la0, la1;
  assign le0 = bus_we;
  assign le1 = bus_we & bus_size;
  assign la0 = bus_addr;
  assign la1 = 8'(bus_addr + 8'd1);

  function automatic logic hit(input logic [7:0] a);
    return (le0 && la0 == a) || (le1 && la1 == a);
  endfunction

  function automatic logic [7:0] wdat(input logic [7:0] a);
    return (le0 && la0 == a) ? bus_wdata[7:0] : bus_wdata[15:8];
  endfunction

  function automatic logic wbit(input logic [7:0] a, input int i);
    logic [7:0] d;
    d = wdat(a);
    return d[i];
  endfunction

  function automatic logic [7:0] base(input int p);
    return 8'(p * STRIDE);
  endfunction

  always_comb begin
    for (int p = 0; p < NPORTS; p++)
      clr[p] = hit(base(p) + OFS_ST) ? NSRC'(wdat(base(p) + OFS_ST)) : '0;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_pend
    assign pend[p] = |(st[p] & ~msk[p][NSRC-1:0]);
  end

  assign gflag   = |(pend & ~hmsk_p) | (sw & ~hmsk_sw);
  assign irq_out = gflag & ~off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORTS; p++) begin
        st[p]  <= '0;
        msk[p] <= MASK_RST;
      end
      hmsk_p  <= '1;
      hmsk_sw <= 1'b1;
      sw      <= 1'b0;
      off     <= 1'b1;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        st[p] <= (st[p] & ~clr[p]) | evt_in[p*NSRC +: NSRC];
        if (hit(base(p) + OFS_MK)) msk[p] <= wdat(base(p) + OFS_MK);
      end
      if (hit(A_HCTL))  off     <= wbit(A_HCTL, 0);
      if (hit(A_HST_H)) sw      <= wbit(A_HST_H, 6);
      if (hit(A_HMK_H)) hmsk_sw <= wbit(A_HMK_H, 6);
      if (hit(A_HMK_L))
        for (int i = 0; i < NPORTS; i++) hmsk_p[i] <= wbit(A_HMK_L, i);
    end
  end

  function automatic logic [7:0] rd_byte(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h00;
    case (a)
      A_HCTL:  r = {7'b0, off};
      A_HST_L: r = 8'(pend);
      A_HST_H: r = {gflag, sw, 6'b0};
      A_HMK_L: r = 8'(hmsk_p);
      A_HMK_H: r = {1'b0, hmsk_sw, 6'b0};
      default: r = 8'h00;
    endcase
    for (int p = 0; p < NPORTS; p++) begin
      if (a == base(p) + OFS_ST) r = {pend[p], 1'b0, st[p]};
      if (a == base(p) + OFS_MK) r = msk[p];
    end
    return r;
  endfunction

  assign bus_rdata = {bus_size ? rd_byte(la1) : 8'h00, rd_byte(la0)};

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((st[p] & $past(evt_in[p*NSRC +: NSRC])) == $past(evt_in[p*NSRC +: NSRC]))); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[p] != '0) |=> ((st[p] & $past(clr[p]) & ~$past(evt_in[p*NSRC +: NSRC])) == '0)); // R3
    AST_ST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[p] == '0 && evt_in[p*NSRC +: NSRC] == '0) |=> $stable(st[p])); // R2
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> !irq_out); // R9
  AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((|pend) || sw)); // R8
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_size = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [11:0] evt_in = '0;
  logic        irq_out;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_aggregator uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .irq_out(irq_out));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic sz, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic sz, output logic [15:0] d);
    bus_addr = a; bus_size = sz;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input int p, input logic [5:0] bits);
    @(negedge clk);
    evt_in[p*6 +: 6] = bits;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(8'h09, 0, d); chk("R1 port0 status", d, 16'h0000);
    rd(8'h0A, 0, d); chk("R1 port0 mask", d, 16'h00FF);
    rd(8'h4A, 0, d); chk("R1 port1 mask", d, 16'h00FF);
    rd(8'hBC, 1, d); chk("R1 host status", d, 16'h0000);
    rd(8'hBE, 1, d); chk("R1 host mask", d, 16'h4003);
    rd(8'h7C, 1, d); chk("R1 host control", d, 16'h0100);
    chk("R1 irq_out", {15'b0, irq_out}, 16'h0000);
  endtask

  task automatic t_events;
    logic [15:0] d;
    pulse(0, 6'b000101);
    rd(8'h09, 0, d); chk("R2 port0 events", d, 16'h0005);
    pulse(1, 6'b100000);
    rd(8'h49, 0, d); chk("R11 port1 bank events", d, 16'h0020);
    rd(8'h09, 0, d); chk("R11 port0 untouched", d, 16'h0005);
  endtask

  task automatic t_w1c;
    logic [15:0] d;
    wr(8'h09, 0, 16'h00C4);
    rd(8'h09, 0, d); chk("R3 clear bit2 only", d, 16'h0001);
    wr(8'h09, 0, 16'h00FF);
    rd(8'h09, 0, d); chk("R3 clear all", d, 16'h0000);
    wr(8'h49, 0, 16'h00FF);
    rd(8'h49, 0, d); chk("R3 clear port1", d, 16'h0000);
  endtask

  task automatic t_collision;
    logic [15:0] d;
    @(negedge clk);
    bus_addr = 8'h09; bus_size = 0; bus_wdata = 16'h0002; bus_we = 1'b1;
    evt_in[5:0] = 6'b000010;
    @(negedge clk);
    bus_we = 1'b0; evt_in = '0;
    rd(8'h09, 0, d); chk("R4 set wins over clear", d, 16'h0002);
  endtask

  task automatic t_pend;
    logic [15:0] d;
    wr(8'h0A, 0, 16'h0030);
    rd(8'h0A, 0, d); chk("R6 mask readback", d, 16'h0030);
    rd(8'h09, 0, d); chk("R5 pending set", d, 16'h0082);
    wr(8'h0A, 0, 16'h00C2);
    rd(8'h09, 0, d); chk("R5 masked source no pending", d, 16'h0002);
    wr(8'h0A, 0, 16'h00C0);
    rd(8'h09, 0, d); chk("R5 mask bits 7:6 ignored", d, 16'h0082);
  endtask

  task automatic t_host;
    logic [15:0] d;
    rd(8'hBC, 1, d); chk("R7 host port bit", d, 16'h0001);
    wr(8'hBE, 1, 16'h0000);
    rd(8'hBC, 1, d); chk("R8 global flag", d, 16'h8001);
    wr(8'hBC, 1, 16'h0002);
    rd(8'hBC, 1, d); chk("R7 port bits write ignored", d, 16'h8001);
    wr(8'h09, 0, 16'h00FF);
    rd(8'hBC, 1, d); chk("R7 port bit follows clear", d, 16'h0000);
    wr(8'hBD, 0, 16'h0040);
    rd(8'hBC, 1, d); chk("R8 software bit", d, 16'hC000);
    wr(8'hBE, 1, 16'hFFFF);
    rd(8'hBE, 1, d); chk("R8 host mask stored bits", d, 16'h4003);
    rd(8'hBC, 1, d); chk("R8 masked software bit", d, 16'h4000);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    wr(8'hBE, 1, 16'h0000);
    chk("R9 off bit holds irq low", {15'b0, irq_out}, 16'h0000);
    wr(8'h7C, 1, 16'h0000);
    chk("R9 irq on", {15'b0, irq_out}, 16'h0001);
    wr(8'h7D, 0, 16'h0001);
    chk("R9 irq forced off", {15'b0, irq_out}, 16'h0000);
    wr(8'h7C, 1, 16'h0000);
    wr(8'hBD, 0, 16'h0000);
    chk("R9 no source no irq", {15'b0, irq_out}, 16'h0000);
    wr(8'h4A, 0, 16'h0000);
    pulse(1, 6'b010000);
    chk("R9 port1 event raises irq", {15'b0, irq_out}, 16'h0001);
    rd(8'hBC, 1, d); chk("R7 port1 host bit", d, 16'h8002);
  endtask

  task automatic t_half;
    logic [15:0] d;
    wr(8'h49, 1, 16'h0AFF);
    rd(8'h49, 1, d); chk("R10 halfword write/read", d, 16'h0A00);
    chk("R10 irq after clear", {15'b0, irq_out}, 16'h0000);
    rd(8'h4A, 0, d); chk("R10 byte read upper zero", d, 16'h000A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset; t_events; t_w1c; t_collision; t_pend; t_host; t_irq; t_half;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule